// File: doc/BRIEF.md
# Shared SPI/I2C Device Select Fan-Out

This block sits between one SPI controller that has a single slave select and one I2C controller, and a row of eight device pins. It lets the two controllers reach up to eight devices between them. Each pin is set up as either an SPI select line or a private, gated copy of the I2C clock. In SPI mode, a device index from the host picks which pin repeats the controller's select.

In I2C mode, each pin passes the bus clock only while its enable bit is set. Otherwise it stays low, so that device never sees a start condition. This is how several I2C devices that share one address are kept apart: only the enabled device receives clocks.

Software writes the mode and enable words into staging registers through a simple write port. The block copies them into the applied configuration only on a clock edge where the SPI select is deasserted and the I2C bus is idle, so no pin ever shows a cut pulse. A readback port always shows the applied words.

Top module: `dev_sel_fanout`

## Requirements
- R1: After reset every pin is in SPI mode with its enable clear, the readback is all zeros, and every pin is high while the SPI select input is high.
- R2: A pin in SPI mode (mode bit 0) is low exactly when the select input `spi_sel_n` is low and `spi_dev` equals that pin's index; otherwise it is high.
- R3: A pin in I2C mode (mode bit 1) whose enable bit is 1 follows `i2c_scl` combinationally.
- R4: A pin in I2C mode whose enable bit is 0 is low, whatever `i2c_scl` does.
- R5: Pins in SPI mode are not affected by `i2c_scl` or by their enable bits.
- R6: Pins in I2C mode are not affected by `spi_sel_n` or `spi_dev`.
- R7: A write with `cfg_field`=0 loads the mode word and a write with `cfg_field`=1 loads the enable word into staging at the next rising edge. The staged words reach the pins at the following rising edge at which both buses are idle.
- R8: While `spi_sel_n` is low at a rising edge, the applied configuration does not change at that edge.
- R9: From an I2C start (SDA falling while SCL is high on two consecutive samples) up to the matching stop (SDA rising while SCL is high), the applied configuration does not change.
- R10: `cfg_rdata` shows the applied words combinationally: enable in bits 15:8, mode in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | Native active-low SPI select |
| spi_dev | input | 3 | Index of the SPI device being addressed |
| i2c_scl | input | 1 | I2C clock from the controller |
| i2c_sda | input | 1 | I2C data, watched to detect start and stop |
| cfg_wr | input | 1 | Write strobe |
| cfg_field | input | 1 | 0 selects the mode word, 1 selects the enable word |
| cfg_wdata | input | 8 | Write data, one bit per pin |
| cfg_rdata | output | 16 | Applied enable and mode words |
| pin_out | output | 8 | Device pins |

## Verification
The pins and the readback are combinational from the inputs and the applied configuration, so they change in the same cycle as their inputs. A write appears at the ports no earlier than the second rising edge after the strobe, and later if a bus is active. The reference model in the bench updates its staging, applied and bus-state values at each rising edge, using the inputs the bench drove at the preceding falling edge. The bench compares every pin and the readback one time unit after each rising edge, so each result is sampled after the edge that updates it and before any new input arrives.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  typedef enum logic {
    PIN_SPI = 1'b0,
    PIN_I2C = 1'b1
  } pin_mode_e;

  typedef enum logic {
    FLD_MODE   = 1'b0,
    FLD_ENABLE = 1'b1
  } cfg_field_e;

  // Level of one device pin.
  function automatic logic pin_level(logic is_i2c, logic en, logic scl,
                                     logic sel_n, logic hit);
    logic lvl;
    if (is_i2c) lvl = scl & en;
    else        lvl = ~(~sel_n & hit);
    return lvl;
  endfunction

  // Start: SDA falls while SCL is high on both samples.
  function automatic logic is_start(logic scl_p, logic sda_p, logic scl, logic sda);
    return scl_p & scl & sda_p & ~sda;
  endfunction

  // Stop: SDA rises while SCL is high on both samples.
  function automatic logic is_stop(logic scl_p, logic sda_p, logic scl, logic sda);
    return scl_p & scl & ~sda_p & sda;
  endfunction

endpackage

// File: rtl/dsf_bus_monitor.sv
module dsf_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_evt,
  output logic stop_evt,
  output logic bus_busy
);
  import dsf_pkg::*;

  logic scl_q, sda_q, busy_q;

  assign start_evt = is_start(scl_q, sda_q, scl, sda);
  assign stop_evt  = is_stop(scl_q, sda_q, scl, sda);
  assign bus_busy  = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_evt)     busy_q <= 1'b1;
      else if (stop_evt) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dsf_cfg_regs.sv
module dsf_cfg_regs #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                field,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic                commit_ok,
  output logic [NUM_PINS-1:0] mode_act,
  output logic [NUM_PINS-1:0] en_act
);
  import dsf_pkg::*;

  logic [NUM_PINS-1:0] mode_stg, en_stg;
  logic wr_mode, wr_en;

  assign wr_mode = wr & (field == FLD_MODE);
  assign wr_en   = wr & (field == FLD_ENABLE);

  // Staging side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_stg <= '0;
      en_stg   <= '0;
    end else begin
      if (wr_mode) mode_stg <= wdata;
      if (wr_en)   en_stg   <= wdata;
    end
  end

  // Applied side, copied only while both buses rest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_act <= '0;
      en_act   <= '0;
    end else if (commit_ok) begin
      mode_act <= mode_stg;
      en_act   <= en_stg;
    end
  end
endmodule

// File: rtl/dsf_pin_mux.sv
module dsf_pin_mux #(
  parameter  int NUM_PINS = 8,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] mode_act,
  input  logic [NUM_PINS-1:0] en_act,
  input  logic                scl,
  input  logic                sel_n,
  input  logic [IDX_W-1:0]    dev,
  output logic [NUM_PINS-1:0] pins
);
  import dsf_pkg::*;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit;
    assign hit     = (dev == IDX_W'(i));
    assign pins[i] = pin_level(mode_act[i] == PIN_I2C, en_act[i], scl, sel_n, hit);
  end
endmodule

// File: rtl/dev_sel_fanout.sv
module dev_sel_fanout #(
  parameter  int NUM_PINS = 8,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sel_n,
  input  logic [IDX_W-1:0]      spi_dev,
  input  logic                  i2c_scl,
  input  logic                  i2c_sda,
  input  logic                  cfg_wr,
  input  logic                  cfg_field,
  input  logic [NUM_PINS-1:0]   cfg_wdata,
  output logic [2*NUM_PINS-1:0] cfg_rdata,
  output logic [NUM_PINS-1:0]   pin_out
);

  logic                start_evt, stop_evt, i2c_busy;
  logic                spi_idle, i2c_idle, commit_ok;
  logic [NUM_PINS-1:0] mode_act, en_act;

  dsf_bus_monitor u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (i2c_scl),
    .sda       (i2c_sda),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .bus_busy  (i2c_busy)
  );

  assign spi_idle  = spi_sel_n;
  assign i2c_idle  = ~i2c_busy & ~start_evt;
  assign commit_ok = spi_idle & i2c_idle;

  dsf_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_wr),
    .field     (cfg_field),
    .wdata     (cfg_wdata),
    .commit_ok (commit_ok),
    .mode_act  (mode_act),
    .en_act    (en_act)
  );

  dsf_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .mode_act (mode_act),
    .en_act   (en_act),
    .scl      (i2c_scl),
    .sel_n    (spi_sel_n),
    .dev      (spi_dev),
    .pins     (pin_out)
  );

  assign cfg_rdata = {en_act, mode_act};

endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  spi_sel_n,
  input logic                  i2c_scl,
  input logic                  i2c_busy,
  input logic                  stop_evt,
  input logic [NUM_PINS-1:0]   mode_act,
  input logic [NUM_PINS-1:0]   en_act,
  input logic [2*NUM_PINS-1:0] cfg_rdata,
  input logic [NUM_PINS-1:0]   pin_out
);
  AST_SPI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_sel_n |=> $stable(cfg_rdata)); // R8
  AST_I2C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_busy && !stop_evt) |=> $stable(cfg_rdata)); // R9
  AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act & ~en_act & pin_out) == '0); // R4
  AST_CLK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ {NUM_PINS{i2c_scl}}) & mode_act & en_act) == '0); // R3
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pin_out & ~mode_act)); // R2
  AST_SPI_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sel_n |-> ((pin_out | mode_act) == '1)); // R2
endmodule

bind dev_sel_fanout dsf_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_sel_n (spi_sel_n),
  .i2c_scl   (i2c_scl),
  .i2c_busy  (i2c_busy),
  .stop_evt  (stop_evt),
  .mode_act  (mode_act),
  .en_act    (en_act),
  .cfg_rdata (cfg_rdata),
  .pin_out   (pin_out)
);

// File: tb/tb_dev_sel_fanout.sv
module tb_dev_sel_fanout;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sel_n = 1'b1;
  logic [2:0] spi_dev = 3'd0;
  logic i2c_scl = 1'b1, i2c_sda = 1'b1;
  logic cfg_wr = 1'b0, cfg_field = 1'b0;
  logic [N-1:0] cfg_wdata = '0;
  logic [2*N-1:0] cfg_rdata;
  logic [N-1:0] pin_out;

  int compared = 0, mismatched = 0;
  string phase = "R1 reset";

  // Reference model state
  logic [N-1:0] m_mode_stg = '0, m_en_stg = '0, m_mode = '0, m_en = '0;
  logic m_busy = 1'b0, m_scl_p = 1'b1, m_sda_p = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dev_sel_fanout dut (
    .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_dev(spi_dev),
    .i2c_scl(i2c_scl), .i2c_sda(i2c_sda), .cfg_wr(cfg_wr),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pin_out(pin_out)
  );

  task automatic check_bit(string req, int idx, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] pin %0d actual %b expected %b", req, phase, idx, act, exp);
    end
  endtask

  // Model update on each rising edge, compare one unit later
  always @(posedge clk) begin
    bit start, stop, commit;
    if (!rst_n) begin
      m_mode_stg = '0; m_en_stg = '0; m_mode = '0; m_en = '0;
      m_busy = 1'b0; m_scl_p = 1'b1; m_sda_p = 1'b1;
    end else begin
      start  = m_scl_p && i2c_scl && m_sda_p && !i2c_sda;
      stop   = m_scl_p && i2c_scl && !m_sda_p && i2c_sda;
      commit = spi_sel_n && !m_busy && !start;
      if (commit) begin m_mode = m_mode_stg; m_en = m_en_stg; end
      if (cfg_wr) begin
        if (cfg_field) m_en_stg = cfg_wdata; else m_mode_stg = cfg_wdata;
      end
      if (start) m_busy = 1'b1;
      else if (stop) m_busy = 1'b0;
      m_scl_p = i2c_scl; m_sda_p = i2c_sda;
    end
    #1;
    for (int i = 0; i < N; i++) begin
      logic e;
      if (m_mode[i]) begin
        e = i2c_scl & m_en[i];
        check_bit(m_en[i] ? "R3" : "R4", i, pin_out[i], e);
      end else begin
        e = !(!spi_sel_n && (int'(spi_dev) == i));
        check_bit("R2", i, pin_out[i], e);
      end
    end
    compared++;
    if (cfg_rdata !== {m_en, m_mode}) begin
      mismatched++;
      $display("FAIL R10 [%s] readback actual %h expected %h", phase, cfg_rdata, {m_en, m_mode});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic fld, logic [N-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic scl_toggle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); i2c_scl = ~i2c_scl;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: reset state seen on pins and readback
    phase = "R1 reset"; idle(3);
    // R2: walk the select over every index
    phase = "R2 spi walk";
    for (int d = 0; d < N; d++) begin
      @(negedge clk); spi_sel_n = 1'b0; spi_dev = 3'(d);
      idle(2);
      @(negedge clk); spi_sel_n = 1'b1;
    end
    // R5: SPI-mode pins ignore the I2C clock and the enable word
    phase = "R5 spi ignores scl";
    write_cfg(1'b1, 8'hFF); idle(2);
    scl_toggle(6);
    write_cfg(1'b1, 8'h00); idle(2);
    // R7: staged write lands two edges after the strobe
    phase = "R7 write";
    write_cfg(1'b0, 8'hA5);
    write_cfg(1'b1, 8'h0F);
    idle(3);
    // R3 and R4: enabled and gated I2C pins
    phase = "R3 R4 scl gating";
    scl_toggle(8);
    // R6: I2C pins ignore the SPI select
    phase = "R6 i2c ignores select";
    for (int d = 0; d < N; d++) begin
      @(negedge clk); spi_sel_n = 1'b0; spi_dev = 3'(d);
      @(negedge clk); i2c_scl = ~i2c_scl;
    end
    @(negedge clk); spi_sel_n = 1'b1; i2c_scl = 1'b1;
    idle(2);
    // R8: no change while the select is active
    phase = "R8 spi hold";
    @(negedge clk); spi_sel_n = 1'b0; spi_dev = 3'd1;
    write_cfg(1'b0, 8'h3C);
    idle(4);
    @(negedge clk); spi_sel_n = 1'b1;
    idle(3);
    // R9: no change between start and stop
    phase = "R9 i2c hold";
    @(negedge clk); i2c_scl = 1'b1; i2c_sda = 1'b1;
    @(negedge clk); i2c_sda = 1'b0;
    @(negedge clk); i2c_scl = 1'b0;
    write_cfg(1'b1, 8'hF0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); i2c_sda = k[0];
      @(negedge clk); i2c_scl = 1'b1;
      @(negedge clk); i2c_scl = 1'b0;
    end
    @(negedge clk); i2c_sda = 1'b0;
    @(negedge clk); i2c_scl = 1'b1;
    idle(2);
    @(negedge clk); i2c_sda = 1'b1;
    idle(4);
    phase = "R7 final";
    write_cfg(1'b0, 8'h00);
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule